// File: doc/BRIEF.md
# ADC Trigger and Conversion Sequencer

This block is the digital control side of a successive-approximation converter. A start request can come from software, from a falling edge on an external trigger pin, or from an internal timer-completion pulse. Two configuration bits pick which of these begins a sweep. The sequencer then converts channels 0 up to a programmed last channel, one after another. For each channel it presents a trial code to the analog side and reads back a single comparator bit.

Each per-channel conversion lasts a fixed number of converter clocks. That number depends on the resolution (8 or 10 bits) and on whether sample-and-hold is enabled. Results go to a small result memory with one entry per channel. In DMA mode every result goes to entry 0 instead, and a transfer request pulses after each channel, tagged with the transfer width.

The comparator and the DMA engine are outside the block. The comparator is seen only as the `cmp_in` bit.

Top module: `adc_seq_top`

## Requirements
- R1: With `cfg_hw_trig` = 0, a `start_set` pulse while idle sets `start_bit`, and `busy` goes high on the next clock edge.
- R2: With `cfg_hw_trig` = 1 and `cfg_trig_src` = 0, a sweep begins only on a falling edge of `ext_trig_n` while `start_bit` is set. The pin passes through a two-flop synchroniser first. A falling edge while `start_bit` is clear is ignored, and so is a rising edge.
- R3: With `cfg_hw_trig` = 1 and `cfg_trig_src` = 1, a sweep begins only on a `timer_done` pulse while `start_bit` is set. A pulse while `start_bit` is clear is ignored.
- R4: In hardware-trigger mode, a selected trigger event during a sweep abandons it. The sweep restarts at channel 0 with a fresh cycle count.
- R5: Each channel takes 28 cycles in 8-bit mode with sample-and-hold, 33 in 10-bit with sample-and-hold, 49 in 8-bit without and 59 in 10-bit without. A sweep of N channels keeps `busy` high for exactly N times that length.
- R6: `cfg_hi_res` = 1 places a 10-bit result in bits 9..0 of the result entry. `cfg_hi_res` = 0 places an 8-bit result in bits 7..0. All higher bits read as zero.
- R7: With `cfg_dma` = 0, the result of channel c is stored in entry c for c = 0 to `cfg_last_ch`. Reading it through `rd_addr` gives `rd_data` one clock later.
- R8: With `cfg_dma` = 1, every result is stored in entry 0. `dma_req` pulses for one cycle after each channel, with `dma_wide` = 1 for 10-bit and 0 for 8-bit.
- R9: Resolution, sample-and-hold, DMA mode and last channel are captured when a sweep begins. Changes to them during the sweep have no effect.
- R10: When the last channel completes, `start_bit` clears, `busy` falls and `done` is high for exactly one cycle.
- R11: After reset, `busy`, `start_bit`, `done`, `dma_req` and `rd_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| start_set | input | 1 | Software write pulse that sets the start bit |
| cfg_hw_trig | input | 1 | 0 = software start, 1 = hardware trigger |
| cfg_trig_src | input | 1 | Hardware source: 0 = external pin falling edge, 1 = timer pulse |
| cfg_hi_res | input | 1 | 1 = 10-bit, 0 = 8-bit resolution |
| cfg_snh | input | 1 | 1 = sample-and-hold enabled |
| cfg_dma | input | 1 | 1 = all results to entry 0 with transfer requests |
| cfg_last_ch | input | 3 | Last channel converted in a sweep |
| ext_trig_n | input | 1 | External trigger pin, asynchronous |
| timer_done | input | 1 | Internal timer-completion pulse |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above `dac_code` |
| dac_code | output | 10 | Trial code presented to the comparator |
| ch_sel | output | 3 | Channel being converted |
| busy | output | 1 | A sweep is running |
| start_bit | output | 1 | Start bit state |
| done | output | 1 | One-cycle pulse at the end of a sweep |
| dma_req | output | 1 | One-cycle transfer request per channel in DMA mode |
| dma_wide | output | 1 | Width tag of the request: 1 = 16-bit, 0 = 8-bit |
| rd_addr | input | 3 | Result entry to read |
| rd_data | output | 16 | Registered read data |

## Verification
The assertions assume that `timer_done` and `start_set` are single-cycle pulses and that `cmp_in` responds within the same cycle to `dac_code`. Under those conditions a successive-approximation search converges on the modelled analog value. The bench drives both pulses for exactly one clock. It derives `cmp_in` continuously from a per-channel analog value compared against `dac_code`, and keeps each value within the selected resolution. Configuration changes made during a sweep never coincide with a retrigger, so the captured settings stay unambiguous.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic {ST_IDLE, ST_CONV} seq_st_t;

  typedef struct packed {
    logic hi_res;
    logic snh;
    logic dma;
  } conv_cfg_t;
endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hw_mode,
  input  logic src_timer,
  input  logic ext_pin_n,
  input  logic timer_evt,
  output logic trig_hit
);
  // sh[0..SYNC_STAGES-1] synchronise, sh[SYNC_STAGES] holds the previous sample
  logic [SYNC_STAGES:0] sh;
  logic                 pin_fall;

  always_ff @(posedge clk) begin
    if (rst) sh[0] <= 1'b1;
    else     sh[0] <= ext_pin_n;
  end

  for (genvar g = 1; g <= SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) sh[g] <= 1'b1;
      else     sh[g] <= sh[g-1];
    end
  end

  assign pin_fall = sh[SYNC_STAGES] & ~sh[SYNC_STAGES-1];
  assign trig_hit = hw_mode & (src_timer ? timer_evt : pin_fall);
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int RES_HI    = 10,
  parameter int RES_LO    = 8,
  parameter int LEN_LO_SH = 28,
  parameter int LEN_HI_SH = 33,
  parameter int LEN_LO    = 49,
  parameter int LEN_HI    = 59,
  localparam int CH_W     = $clog2(NUM_CH),
  localparam int MAX_A    = (LEN_LO > LEN_HI) ? LEN_LO : LEN_HI,
  localparam int MAX_B    = (LEN_LO_SH > LEN_HI_SH) ? LEN_LO_SH : LEN_HI_SH,
  localparam int MAX_LEN  = (MAX_A > MAX_B) ? MAX_A : MAX_B,
  localparam int CNT_W    = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_set,
  input  logic              hw_mode,
  input  logic              trig_hit,
  input  conv_cfg_t         cfg,
  input  logic [CH_W-1:0]   last_ch,
  input  logic              cmp_in,
  output logic [RES_HI-1:0] dac_code,
  output logic [CH_W-1:0]   ch_sel,
  output logic              busy,
  output logic              start_bit,
  output logic              done,
  output logic              wr_en,
  output logic [CH_W-1:0]   wr_addr,
  output logic [RES_HI-1:0] wr_data,
  output logic              wr_hi,
  output logic              dma_req
);
  seq_st_t           st;
  conv_cfg_t         cfg_q;
  logic [CH_W-1:0]   last_q, ch;
  logic [CNT_W-1:0]  cnt, len_q;
  logic [RES_HI-1:0] sar, trial, sar_nx;
  logic [CNT_W-1:0]  nb, win_lo, kk, idx;
  logic              in_win, last_cyc, go, restart;

  function automatic logic [CNT_W-1:0] len_of(input conv_cfg_t c);
    case ({c.hi_res, c.snh})
      2'b00:   return CNT_W'(LEN_LO);
      2'b01:   return CNT_W'(LEN_LO_SH);
      2'b10:   return CNT_W'(LEN_HI);
      default: return CNT_W'(LEN_HI_SH);
    endcase
  endfunction

  // bit decisions occupy the last nb cycles of each channel, MSB first
  always_comb begin
    nb       = cfg_q.hi_res ? CNT_W'(RES_HI) : CNT_W'(RES_LO);
    win_lo   = len_q - nb;
    in_win   = (st == ST_CONV) && (cnt >= win_lo);
    kk       = cnt - win_lo;
    idx      = nb - CNT_W'(1) - kk;
    trial    = in_win ? (sar | (RES_HI'(1) << idx)) : sar;
    sar_nx   = (in_win && cmp_in) ? trial : sar;
    last_cyc = (st == ST_CONV) && (cnt == len_q - CNT_W'(1));
    go       = (st == ST_IDLE) && (start_bit || start_set) && (!hw_mode || trig_hit);
    restart  = (st == ST_CONV) && trig_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cfg_q     <= '0;
      last_q    <= '0;
      ch        <= '0;
      cnt       <= '0;
      len_q     <= CNT_W'(LEN_LO);
      sar       <= '0;
      start_bit <= 1'b0;
      done      <= 1'b0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_hi     <= 1'b0;
      dma_req   <= 1'b0;
    end else begin
      wr_en   <= 1'b0;
      dma_req <= 1'b0;
      done    <= 1'b0;
      if (start_set) start_bit <= 1'b1;
      if (go || restart) begin
        st     <= ST_CONV;
        cfg_q  <= cfg;
        last_q <= last_ch;
        len_q  <= len_of(cfg);
        ch     <= '0;
        cnt    <= '0;
        sar    <= '0;
      end else if (st == ST_CONV) begin
        if (last_cyc) begin
          wr_en   <= 1'b1;
          wr_addr <= cfg_q.dma ? '0 : ch;
          wr_data <= sar_nx;
          wr_hi   <= cfg_q.hi_res;
          dma_req <= cfg_q.dma;
          cnt     <= '0;
          sar     <= '0;
          if (ch == last_q) begin
            st        <= ST_IDLE;
            start_bit <= 1'b0;
            done      <= 1'b1;
          end else begin
            ch <= ch + CH_W'(1);
          end
        end else begin
          sar <= sar_nx;
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  assign busy     = (st == ST_CONV);
  assign ch_sel   = ch;
  assign dac_code = trial;

  // R1
  sw_start_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && start_set && !hw_mode) |=> (st == ST_CONV));
  // R4
  retrig_restart_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (st == ST_CONV && cnt == '0 && ch == '0));
  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CONV) |-> (cnt < len_q));
  // R8
  dma_entry0_chk: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> (wr_en && wr_addr == '0));
  // R8
  dma_single_chk: assert property (@(posedge clk) disable iff (rst)
    dma_req |=> !dma_req);
  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CONV && $past(st == ST_CONV) && !$past(restart)) |-> ($stable(cfg_q) && $stable(last_q)));
  // R10
  done_clear_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!start_bit && st == ST_IDLE));
endmodule

// File: rtl/adc_result_mem.sv
module adc_result_mem #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int RES_HI      = 10,
  parameter int RES_LO      = 8,
  parameter int OUT_W       = 16,
  parameter int LEN_LO_SH   = 28,
  parameter int LEN_HI_SH   = 33,
  parameter int LEN_LO      = 49,
  parameter int LEN_HI      = 59,
  parameter int SYNC_STAGES = 2,
  localparam int CH_W       = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_set,
  input  logic              cfg_hw_trig,
  input  logic              cfg_trig_src,
  input  logic              cfg_hi_res,
  input  logic              cfg_snh,
  input  logic              cfg_dma,
  input  logic [CH_W-1:0]   cfg_last_ch,
  input  logic              ext_trig_n,
  input  logic              timer_done,
  input  logic              cmp_in,
  output logic [RES_HI-1:0] dac_code,
  output logic [CH_W-1:0]   ch_sel,
  output logic              busy,
  output logic              start_bit,
  output logic              done,
  output logic              dma_req,
  output logic              dma_wide,
  input  logic [CH_W-1:0]   rd_addr,
  output logic [OUT_W-1:0]  rd_data
);
  logic              trig_hit, wr_en, wr_hi;
  logic [CH_W-1:0]   wr_addr;
  logic [RES_HI-1:0] wr_data;
  conv_cfg_t         cfg;

  assign cfg = '{hi_res: cfg_hi_res, snh: cfg_snh, dma: cfg_dma};

  adc_trig_sel #(.SYNC_STAGES(SYNC_STAGES)) trig_i (
    .clk(clk), .rst(rst), .hw_mode(cfg_hw_trig), .src_timer(cfg_trig_src),
    .ext_pin_n(ext_trig_n), .timer_evt(timer_done), .trig_hit(trig_hit)
  );

  adc_sar_core #(
    .NUM_CH(NUM_CH), .RES_HI(RES_HI), .RES_LO(RES_LO),
    .LEN_LO_SH(LEN_LO_SH), .LEN_HI_SH(LEN_HI_SH), .LEN_LO(LEN_LO), .LEN_HI(LEN_HI)
  ) core_i (
    .clk(clk), .rst(rst), .start_set(start_set), .hw_mode(cfg_hw_trig),
    .trig_hit(trig_hit), .cfg(cfg), .last_ch(cfg_last_ch), .cmp_in(cmp_in),
    .dac_code(dac_code), .ch_sel(ch_sel), .busy(busy), .start_bit(start_bit),
    .done(done), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_hi(wr_hi), .dma_req(dma_req)
  );

  assign dma_wide = wr_hi;

  adc_result_mem #(.DEPTH(NUM_CH), .DATA_W(OUT_W)) mem_i (
    .clk(clk), .rst(rst), .we(wr_en), .waddr(wr_addr),
    .wdata({{(OUT_W-RES_HI){1'b0}}, wr_data}), .raddr(rd_addr), .rdata(rd_data)
  );

  // R6
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_hi) |-> (wr_data[RES_HI-1:RES_LO] == '0));
endmodule

// File: tb/adc_seq_top_tb_top.sv
`timescale 1ns/1ps
module adc_seq_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_set = 0, cfg_hw_trig = 0, cfg_trig_src = 0;
  logic       cfg_hi_res = 0, cfg_snh = 0, cfg_dma = 0;
  logic [2:0] cfg_last_ch = 0, rd_addr = 0, ch_sel;
  logic       ext_trig_n = 1, timer_done = 0, cmp_in;
  logic [9:0] dac_code;
  logic       busy, start_bit, done, dma_req, dma_wide;
  logic [15:0] rd_data;
  logic [9:0] ain [8];
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  assign cmp_in = (ain[ch_sel] >= dac_code);

  adc_seq_top dut_i (
    .clk(clk), .rst(rst), .start_set(start_set), .cfg_hw_trig(cfg_hw_trig),
    .cfg_trig_src(cfg_trig_src), .cfg_hi_res(cfg_hi_res), .cfg_snh(cfg_snh),
    .cfg_dma(cfg_dma), .cfg_last_ch(cfg_last_ch), .ext_trig_n(ext_trig_n),
    .timer_done(timer_done), .cmp_in(cmp_in), .dac_code(dac_code), .ch_sel(ch_sel),
    .busy(busy), .start_bit(start_bit), .done(done), .dma_req(dma_req),
    .dma_wide(dma_wide), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_len(input bit hi, input bit snh);
    if (hi) return snh ? 33 : 59;
    return snh ? 28 : 49;
  endfunction

  // mode: 0 software, 1 external pin, 2 timer
  task automatic run_sweep(input bit hi, input bit snh, input bit dma, input int last,
                           input int mode, input bit toggle, input bit retrig);
    int L = exp_len(hi, snh);
    int n = last + 1;
    int bcnt = 0, nreq = 0, pend = 0, pend_val = 0, guard = 0, post = 0;
    bit fin = 0, fired = 0;
    @(negedge clk);
    for (int c = 0; c < 8; c++) ain[c] = 10'($urandom) & (hi ? 10'h3FF : 10'h0FF);
    cfg_hi_res = hi; cfg_snh = snh; cfg_dma = dma; cfg_last_ch = 3'(last);
    cfg_hw_trig = (mode != 0); cfg_trig_src = (mode == 2); rd_addr = 0;
    if (mode == 1) begin
      ext_trig_n = 0;
      repeat (4) @(negedge clk);
      chk(!busy, "R2 pin edge with start bit clear ignored", busy, 0);
      start_set = 1; @(negedge clk); start_set = 0;
      ext_trig_n = 1;
      repeat (4) @(negedge clk);
      chk(!busy && start_bit, "R2 rising pin edge ignored", busy, 0);
      ext_trig_n = 0;
    end else if (mode == 2) begin
      timer_done = 1; @(negedge clk); timer_done = 0;
      repeat (2) @(negedge clk);
      chk(!busy, "R3 timer pulse with start bit clear ignored", busy, 0);
      start_set = 1; @(negedge clk); start_set = 0;
      repeat (2) @(negedge clk);
      chk(!busy && start_bit, "R3 waiting for timer pulse", busy, 0);
      timer_done = 1;
    end else begin
      start_set = 1;
    end
    while (!fin || post < 3) begin
      @(negedge clk);
      guard++;
      start_set = 0; timer_done = 0;
      if (mode == 0 && guard == 1) chk(busy, "R1 software start one edge later", busy, 1);
      if (mode == 1 && guard == 6) ext_trig_n = 1;
      if (busy) bcnt++;
      if (toggle && bcnt == 5) begin cfg_hi_res = ~hi; cfg_snh = ~snh; cfg_dma = ~dma; end
      if (retrig && !fired && bcnt == 20) begin timer_done = 1; fired = 1; bcnt = 0; end
      if (pend > 0) begin
        pend--;
        if (pend == 0) chk(rd_data == 16'(pend_val), "R8 result in entry 0", rd_data, pend_val);
      end
      if (dma_req) begin
        chk(dma_wide == hi, "R8 transfer width flag", dma_wide, hi);
        pend_val = (nreq < 8) ? int'(ain[nreq]) : 0;
        pend = 2;
        nreq++;
      end
      if (fin) begin
        post++;
        if (post == 1) chk(!done, "R10 done lasts one cycle", done, 0);
      end
      if (done && !fin) begin
        fin = 1;
        chk(!start_bit && !busy, "R10 start bit cleared at end", start_bit, 0);
      end
      if (guard > 20000) begin
        chk(0, "R5 sweep never finished", guard, n * L);
        break;
      end
    end
    chk(bcnt == n * L, retrig ? "R4 restart gives full sweep length" : "R5 sweep length", bcnt, n * L);
    chk(nreq == (dma ? n : 0), "R8 request count", nreq, dma ? n : 0);
    if (toggle) chk(bcnt == n * L, "R9 mid-sweep config change ignored", bcnt, n * L);
    if (!dma) begin
      for (int c = 0; c <= last; c++) begin
        rd_addr = 3'(c);
        @(negedge clk);
        chk(rd_data == 16'(ain[c]), "R6 R7 per-channel result", rd_data, ain[c]);
      end
    end else begin
      rd_addr = 0;
      @(negedge clk);
      chk(rd_data == 16'(ain[last]), "R8 entry 0 holds last result", rd_data, ain[last]);
    end
    cfg_hw_trig = 0; ext_trig_n = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int c = 0; c < 8; c++) ain[c] = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!busy && !start_bit && !done && !dma_req && rd_data == 0,
        "R11 reset state", {busy, start_bit, done, dma_req}, 0);
    // directed corners
    run_sweep(1, 0, 0, 7, 0, 0, 0);
    run_sweep(0, 1, 0, 0, 0, 0, 0);
    run_sweep(1, 1, 1, 7, 0, 0, 0);
    run_sweep(0, 0, 1, 3, 1, 0, 0);
    run_sweep(1, 1, 0, 5, 2, 0, 1);
    run_sweep(0, 1, 0, 4, 0, 1, 0);
    // constrained random
    for (int i = 0; i < 24; i++) begin
      int mode = $urandom_range(0, 2);
      bit rt = (mode == 2) && ($urandom_range(0, 2) == 0);
      bit tg = !rt && ($urandom_range(0, 3) == 0);
      run_sweep(1'($urandom), 1'($urandom), 1'($urandom), $urandom_range(0, 7), mode, tg, rt);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #750000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule